// File: doc/BRIEF.md
# Strobed Single-Bit Static RAM

This block is a clocked model of a small static memory of 64 words, one bit wide. A 6-bit address selects a word, and a single data bit is written into it or read out of it. An access takes place only in a clock cycle where the strobe and both enable qualifiers are high. The direction select then picks a write, when it is low, or a read, when it is high.

The read port stands in for a three-state pin. It is modelled as a data bit plus an active-high output-enable flag. When a read begins, the output becomes enabled but is held at 0 for a parameterised number of clock cycles, `ACCESS_CYCLES`, and only then shows the stored bit. This low interval starts again whenever the read access drops or the address moves. The storage array has no reset. The reset clears only the read-latency tracking and the output stage.

Top module: `strobed_bit_ram`

## Requirements
- R1: The memory holds 64 independent one-bit words, and each value of `addr` (0 to 63) selects exactly one of them.
- R2: An access takes place only in a cycle where `strobe`, `en_a` and `en_b` are all 1. In any other cycle nothing is written, and `dout_oe` is 0 in the following cycle.
- R3: A write access (`rd_sel` = 0) stores `din` into the word at `addr` at that clock edge. `dout_oe` is 0 in the following cycle.
- R4: After every clock edge at which a read access (`rd_sel` = 1) was sampled, `dout_oe` is 1. After every other edge it is 0.
- R5: For the first `ACCESS_CYCLES` cycles in which `dout_oe` is 1 for a read run, `dout` is 0.
- R6: From cycle `ACCESS_CYCLES`+1 of a read run onward, `dout` equals the bit last written to that word, with the same polarity.
- R7: A read run restarts, with a fresh low interval, when the read access drops for a cycle or when the address differs from the previous cycle's read address.
- R8: `dout` is 0 in every cycle in which `dout_oe` is 0.
- R9: While `rst_n` is low, `dout_oe` and `dout` are 0. The memory contents are kept across a reset.
- R10: `rd_sel` may stay high across back-to-back reads, and low across back-to-back writes, with every access taking effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| addr | input | 6 | Word address |
| din | input | 1 | Write data bit |
| rd_sel | input | 1 | Direction select: 1 = read, 0 = write |
| strobe | input | 1 | Access strobe |
| en_a | input | 1 | First enable qualifier |
| en_b | input | 1 | Second enable qualifier |
| dout | output | 1 | Read data bit, 0 whenever not enabled |
| dout_oe | output | 1 | Output-enable flag for `dout` |

## Verification
The assertions check several properties on every cycle. The output enable must follow the sampled read access one edge later. Writes and disabled cycles must leave the output off. Data must be 0 while the output is off. The first output cycle of a read run, and the first cycle after an address change, must be low. What only the bench's scenarios can show is the memory function itself. Its scenarios write all 64 words and read them back, check that the data bit appears with the right polarity after exactly `ACCESS_CYCLES` low cycles, confirm that disabled combinations really changed no stored word, and show that the contents survive a reset.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  // Output stage of the read path: an enable flag plus the driven bit.
  typedef struct packed {
    logic oe;
    logic data;
  } sbr_out_t;

  localparam sbr_out_t SBR_OUT_OFF = '{oe: 1'b0, data: 1'b0};
endpackage

// File: rtl/sbr_store.sv
module sbr_store #(
  parameter int WORDS = 64,
  parameter int AW    = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_bit,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_bit
);
  logic [WORDS-1:0] bits;

  // One flop per word with its own decoded clock enable; no reset on storage.
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic sel;
    assign sel = wr_en && (wr_addr == AW'(w));
    always_ff @(posedge clk) begin
      if (sel) begin
        bits[w] <= wr_bit;
      end
    end
  end

  assign rd_bit = bits[rd_addr];
endmodule

// File: rtl/sbr_latency.sv
module sbr_latency #(
  parameter int ACCESS_CYCLES = 2,
  parameter int AW            = 6,
  localparam int CW           = $clog2(ACCESS_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_act,
  input  logic [AW-1:0] addr,
  output logic          data_ok
);
  logic [CW-1:0] run_q, run_d;
  logic [AW-1:0] prev_addr_q, prev_addr_d;
  logic          prev_rd_q, prev_rd_d;
  logic          same_run;

  always_comb begin
    same_run    = prev_rd_q && (addr == prev_addr_q);
    prev_rd_d   = rd_act;
    prev_addr_d = rd_act ? addr : prev_addr_q;
    run_d       = '0;
    if (rd_act && same_run) begin
      run_d = (run_q == CW'(ACCESS_CYCLES)) ? run_q : run_q + CW'(1);
    end
    data_ok = rd_act && (run_d == CW'(ACCESS_CYCLES));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q       <= '0;
      prev_addr_q <= '0;
      prev_rd_q   <= 1'b0;
    end else begin
      run_q       <= run_d;
      prev_addr_q <= prev_addr_d;
      prev_rd_q   <= prev_rd_d;
    end
  end
endmodule

// File: rtl/sbr_outstage.sv
module sbr_outstage
  import sbr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     rd_act,
  input  logic     data_ok,
  input  logic     mem_bit,
  output sbr_out_t out_q
);
  sbr_out_t out_d;

  always_comb begin
    out_d      = SBR_OUT_OFF;
    out_d.oe   = rd_act;
    out_d.data = rd_act && data_ok && mem_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= SBR_OUT_OFF;
    end else begin
      out_q <= out_d;
    end
  end
endmodule

// File: rtl/strobed_bit_ram.sv
module strobed_bit_ram
  import sbr_pkg::*;
#(
  parameter int WORDS         = 64,
  parameter int ACCESS_CYCLES = 2,
  localparam int AW           = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          din,
  input  logic          rd_sel,
  input  logic          strobe,
  input  logic          en_a,
  input  logic          en_b,
  output logic          dout,
  output logic          dout_oe
);
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  logic       access, rd_act, wr_act;
  logic       data_ok, mem_bit;
  sbr_out_t   out_q;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  assign access = strobe && en_a && en_b;
  assign rd_act = access && rd_sel;
  assign wr_act = access && !rd_sel;

  sbr_store #(.WORDS(WORDS), .AW(AW)) u_store (
    .clk     (clk),
    .wr_en   (wr_act),
    .wr_addr (addr),
    .wr_bit  (din),
    .rd_addr (addr),
    .rd_bit  (mem_bit)
  );

  sbr_latency #(.ACCESS_CYCLES(ACCESS_CYCLES), .AW(AW)) u_latency (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .rd_act  (rd_act),
    .addr    (addr),
    .data_ok (data_ok)
  );

  sbr_outstage u_out (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .rd_act  (rd_act),
    .data_ok (data_ok),
    .mem_bit (mem_bit),
    .out_q   (out_q)
  );

  assign dout    = out_q.data;
  assign dout_oe = out_q.oe;
endmodule

// File: rtl/sbr_checker.sv
module sbr_checker #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          rd_sel,
  input logic          strobe,
  input logic          en_a,
  input logic          en_b,
  input logic          dout,
  input logic          dout_oe
);
  logic qual;
  assign qual = strobe && en_a && en_b;

  AST_OE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (qual && rd_sel) |=> dout_oe); // R4

  AST_OE_OFF_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !qual |=> !dout_oe); // R2

  AST_OE_OFF_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (qual && !rd_sel) |=> !dout_oe); // R3

  AST_DATA_ZERO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe |-> !dout); // R8

  AST_FIRST_READ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_oe) |-> !dout); // R5

  AST_ADDR_MOVE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (qual && rd_sel && $past(qual && rd_sel) && (addr != $past(addr))) |=> !dout); // R7
endmodule

bind strobed_bit_ram sbr_checker #(.AW(AW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .addr    (addr),
  .rd_sel  (rd_sel),
  .strobe  (strobe),
  .en_a    (en_a),
  .en_b    (en_b),
  .dout    (dout),
  .dout_oe (dout_oe)
);

// File: tb/tb_strobed_bit_ram.sv
`timescale 1ns/1ps
module tb_strobed_bit_ram;
  localparam int AC = 2;

  logic       clk, rst_n;
  logic [5:0] addr;
  logic       din, rd_sel, strobe, en_a, en_b;
  logic       dout, dout_oe;

  typedef struct {
    logic  oe;
    logic  d;
    string tag;
  } exp_t;

  exp_t q[$];
  int   compared = 0;
  int   mismatched = 0;

  // Bench-side reference state, derived from the requirements.
  logic       model [64];
  logic       m_prev_rd;
  logic [5:0] m_prev_addr;
  int         m_run;

  strobed_bit_ram #(.ACCESS_CYCLES(AC)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .rd_sel(rd_sel),
    .strobe(strobe), .en_a(en_a), .en_b(en_b), .dout(dout), .dout_oe(dout_oe)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic pat(input logic [5:0] a);
    return a[0] ^ a[2] ^ a[5];
  endfunction

  // Driver: applies one cycle of stimulus and queues the expected output.
  task automatic cyc(input logic [5:0] a, input logic d, input logic rd,
                     input logic st, input logic e1, input logic e2,
                     input string tag);
    exp_t e;
    logic acc, ra, same;
    @(negedge clk);
    addr = a; din = d; rd_sel = rd; strobe = st; en_a = e1; en_b = e2;
    acc  = st && e1 && e2;
    ra   = acc && rd;
    same = m_prev_rd && (a == m_prev_addr);
    if (ra && same) m_run = (m_run < AC) ? m_run + 1 : AC;
    else            m_run = 0;
    e.oe  = ra;
    e.d   = ra && (m_run >= AC) ? model[a] : 1'b0;
    e.tag = tag;
    q.push_back(e);
    if (acc && !rd) model[a] = d;
    m_prev_rd = ra;
    if (ra) m_prev_addr = a;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(6'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2 idle");
  endtask

  task automatic read_run(input logic [5:0] a, input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(a, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, tag);
  endtask

  // Monitor: pops one expectation per clock edge and compares.
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      compared++;
      if (dout_oe !== e.oe || dout !== e.d) begin
        mismatched++;
        $display("FAIL %s: oe/dout actual %b/%b expected %b/%b at %0t",
                 e.tag, dout_oe, dout, e.oe, e.d, $time);
      end
    end
  end

  task automatic direct_check(input logic ok, input string tag,
                              input logic [1:0] act, input logic [1:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    wait (q.size() == 0);
    @(negedge clk);
    rst_n = 1'b0;
    strobe = 1'b0; en_a = 1'b0; en_b = 1'b0; rd_sel = 1'b0; din = 1'b0; addr = '0;
    repeat (3) @(negedge clk);
    direct_check(dout_oe === 1'b0 && dout === 1'b0, "R9 outputs off in reset",
                 {dout_oe, dout}, 2'b00);
    rst_n = 1'b1;
    m_prev_rd = 1'b0; m_run = 0; m_prev_addr = '0;
    idle(3);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b1; addr = '0; din = 1'b0; rd_sel = 1'b0;
    strobe = 1'b0; en_a = 1'b0; en_b = 1'b0;
    m_prev_rd = 1'b0; m_run = 0; m_prev_addr = '0;
    for (int i = 0; i < 64; i++) model[i] = 1'b0;
    #1 rst_n = 1'b0;
    do_reset();

    // R3 R10: fill every word with rd_sel held low throughout.
    for (int a = 0; a < 64; a++)
      cyc(6'(a), pat(6'(a)), 1'b0, 1'b1, 1'b1, 1'b1, "R3 R10 write");

    // R1 R5 R6: read each word back with full latency.
    for (int a = 0; a < 64; a++) begin
      read_run(6'(a), AC + 1, "R1 R5 R6 readback");
      idle(1);
    end

    // R10: back-to-back read held on one word, rd_sel never toggling.
    read_run(6'd5, AC + 4, "R10 long read");

    // R7: address change inside a run restarts the low interval.
    read_run(6'd1, AC + 1, "R7 run A");
    read_run(6'd2, AC + 2, "R7 moved address");
    // R7: access drop for one cycle, same address, then resume.
    cyc(6'd2, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R7 drop");
    read_run(6'd2, AC + 1, "R7 resume");

    // R2: every combination with some qualifier low, as read and as write.
    for (int c = 0; c < 7; c++) begin
      logic [2:0] k;
      k = 3'(c);
      cyc(6'(9 + c), 1'b0, 1'b1, k[2], k[1], k[0], "R2 disabled read");
      cyc(6'(9 + c), ~pat(6'(9 + c)), 1'b0, k[2], k[1], k[0], "R2 disabled write");
    end
    for (int c = 0; c < 7; c++) begin
      read_run(6'(9 + c), AC + 1, "R2 word unchanged");
      idle(1);
    end

    // R6: polarity of inverted data after rewrite.
    cyc(6'd40, ~pat(6'd40), 1'b0, 1'b1, 1'b1, 1'b1, "R3 rewrite");
    read_run(6'd40, AC + 2, "R6 inverted polarity");

    // R9: contents survive reset.
    do_reset();
    for (int a = 60; a < 64; a++) begin
      read_run(6'(a), AC + 1, "R9 retained after reset");
      idle(1);
    end

    idle(2);
    wait (q.size() == 0);
    @(negedge clk);
    finish_run();
  end
endmodule